// File: doc/BRIEF.md
# Multi-Word Entry Hardware Queue

This block is one hardware FIFO queue whose storage lives in a word-wide buffer RAM. A host reaches it through a small word-addressed register window. An entry is 1, 2 or 4 words long. A push is a run of word writes to a 4-word access window. A pop is a run of word reads from the same window. In both cases the first word of the entry goes through the first slot of the window. The queue holds a buffer base, a size in words, an entry size, read and write pointers, an occupancy count and two watermarks. From these it derives four status bits.

Popping an empty queue and pushing a full queue are both errors. Each error sets a sticky flag, and software clears the flag by writing a zero to its bit. A second window gives random access to any queued entry by its index from the head. Through it the host can read an entry (peek) or overwrite it (poke) without disturbing either pointer.

Register map (4-bit word address): 0-3 queue window, 4 configuration, 5 watermarks, 6 status, 7 error flags, 8 pointers, 9 peek index, 12-15 peek/poke window. Each field sits in an 8-bit lane: lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16.

Top module: `mwq_queue`

## Requirements
- R1: After reset the queue is empty with base 0, size 16 words and 1-word entries, so the configuration register reads 0x00001000. Both watermarks, both pointers, the count and both error flags are zero. The status reads 4'b0011 (bit0 empty, bit1 nearly-empty, bit2 nearly-full, bit3 full).
- R2: Entries come out in the order they went in. Word k of an entry is written or read through window address k (0-3).
- R3: The configuration register holds base in lane 0, size in words in lane 1 and an entry-size code in bits 17:16. Code 0 means 1 word, code 1 means 2 words and code 2 means 4 words. A valid write sets these fields and clears the pointers, the count and any partial transfer. Capacity in entries is size divided by entry size.
- R4: Pointers, count and status change only on the edge that completes the last word of an entry. A partly pushed entry is never counted or popped.
- R5: A pop started on an empty queue returns 0 for every word of that entry and sets the underflow flag (flag bit 0). It moves no pointer.
- R6: A push started on a full queue sets the overflow flag (flag bit 1), discards all its words and moves no pointer. Queued data is left intact.
- R7: Error flags stay set until a write to the flag register with a 0 in that bit. Writing a 1 leaves the flag unchanged.
- R8: Nearly-empty is set when count is at or below the nearly-empty watermark (watermark register lane 0). Nearly-full is set when capacity minus count is at or below the nearly-full watermark (lane 1). Empty is set when count is 0, and full when count equals capacity.
- R9: A configuration write with entry-size code 3 is rejected and changes nothing.
- R10: Address 9 holds an entry index. Window word k at address 12+k reads (peek) or overwrites (poke) word k of the entry at that index from the head. Neither pointer moves. For k not below the entry size, reads return 0 and writes are dropped.
- R11: Pointers are word offsets that wrap to 0 at the queue size. The pointer register holds the read pointer in lane 0, the write pointer in lane 1 and the count in lane 2.
- R12: A queue-window access whose address is not the next expected word of the entry in progress is ignored. A read of this kind returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Word address in the register window |
| req_wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational for the current access |
| status | output | 4 | {full, nearly-full, nearly-empty, empty} |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |

## Verification
A corrupted pointer shows up on the next pop as a wrong or stale word on rdata. It also shows on any pointer-register read. A wrong count or word sequence shows in the status bits. Such an error appears either at the edge that completes the entry or one edge early, because of a partial word. A lost sticky flag is visible on the flag outputs one cycle later. The tests therefore sample status after every word of an entry and pop data back out after each fill, so that each fault appears within the same scenario that causes it.

// File: rtl/mwq_pkg.sv
package mwq_pkg;
    // Window selection on req_addr[3:2]
    localparam logic [1:0] WIN_QUEUE = 2'd0;
    localparam logic [1:0] WIN_PEEK  = 2'd3;

    // Single registers
    localparam logic [3:0] REG_CFG    = 4'd4;
    localparam logic [3:0] REG_WMARK  = 4'd5;
    localparam logic [3:0] REG_STATUS = 4'd6;
    localparam logic [3:0] REG_FLAGS  = 4'd7;
    localparam logic [3:0] REG_PTRS   = 4'd8;
    localparam logic [3:0] REG_PIDX   = 4'd9;

    // Width of one field lane inside a register word
    localparam int LANE = 8;

    // Entry-size code: words per entry = 1 << code
    typedef enum logic [1:0] {
        ESZ_1   = 2'd0,
        ESZ_2   = 2'd1,
        ESZ_4   = 2'd2,
        ESZ_BAD = 2'd3
    } esz_e;

    // Status and flag bit positions
    localparam int ST_EMPTY = 0;
    localparam int ST_NE    = 1;
    localparam int ST_NF    = 2;
    localparam int ST_FULL  = 3;
    localparam int FLAG_UF  = 0;
    localparam int FLAG_OF  = 1;
endpackage

// File: rtl/mwq_ram.sv
module mwq_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/mwq_status.sv
module mwq_status #(
    parameter int FW = 7
) (
    input  logic [FW-1:0] cnt,
    input  logic [FW-1:0] cap,
    input  logic [FW-1:0] ne_wm,
    input  logic [FW-1:0] nf_wm,
    output logic [3:0]    status
);
    import mwq_pkg::*;

    logic [FW-1:0] free_slots;

    always_comb begin
        free_slots       = (cnt >= cap) ? '0 : cap - cnt;
        status           = '0;
        status[ST_EMPTY] = (cnt == '0);
        status[ST_NE]    = (cnt <= ne_wm);
        status[ST_NF]    = (free_slots <= nf_wm);
        status[ST_FULL]  = (cnt >= cap);
    end
endmodule

// File: rtl/mwq_queue.sv
module mwq_queue
    import mwq_pkg::*;
#(
    parameter int AW       = 6,
    parameter int DW       = 32,
    parameter int RST_SIZE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [3:0]    req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rdata,
    output logic [3:0]    status,
    output logic          underflow,
    output logic          overflow
);
    localparam int FW = AW + 1;   // pointer / count / size width
    localparam int OW = FW + 3;   // peek offset width before wrap

    typedef struct packed {
        logic [AW-1:0] base;
        logic [FW-1:0] size;
        logic [1:0]    ecode;
        logic [FW-1:0] ne_wm;
        logic [FW-1:0] nf_wm;
        logic [FW-1:0] rptr;
        logic [FW-1:0] wptr;
        logic [FW-1:0] cnt;
        logic [1:0]    rseq;
        logic [1:0]    wseq;
        logic          rdrop;
        logic          wdrop;
        logic          uf;
        logic          of;
        logic [FW-1:0] pidx;
    } st_t;

    localparam st_t RST_ST = '{size: FW'(RST_SIZE), default: '0};

    st_t q, d;

    logic [FW-1:0] ewords, cap;
    logic [AW-1:0] raddr, waddr;
    logic [DW-1:0] rword, wword;
    logic          we_ram;
    logic          pop_drop, push_drop;
    logic [OW-1:0] poff_raw, poff;
    logic [1:0]    win, k;

    function automatic logic [FW-1:0] wrap_add(input logic [FW-1:0] ptr,
                                               input logic [FW-1:0] step,
                                               input logic [FW-1:0] lim);
        logic [FW:0] nxt;
        nxt = {1'b0, ptr} + {1'b0, step};
        if (nxt >= {1'b0, lim}) begin
            nxt = nxt - {1'b0, lim};
        end
        return nxt[FW-1:0];
    endfunction

    assign ewords = FW'(1) << q.ecode;
    assign cap    = q.size >> q.ecode;
    assign win    = req_addr[3:2];
    assign k      = req_addr[1:0];

    mwq_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (we_ram),
        .waddr (waddr),
        .wdata (wword),
        .raddr (raddr),
        .rword (rword)
    );

    mwq_status #(.FW(FW)) u_status (
        .cnt    (q.cnt),
        .cap    (cap),
        .ne_wm  (q.ne_wm),
        .nf_wm  (q.nf_wm),
        .status (status)
    );

    always_comb begin
        poff_raw = OW'(q.rptr) + (OW'(q.pidx) << q.ecode) + OW'(k);
        poff     = (poff_raw >= OW'(q.size)) ? poff_raw - OW'(q.size) : poff_raw;
    end

    always_comb begin
        d         = q;
        we_ram    = 1'b0;
        waddr     = q.base + AW'(q.wptr) + AW'(q.wseq);
        wword     = req_wdata;
        raddr     = q.base + AW'(q.rptr) + AW'(q.rseq);
        rdata     = '0;
        pop_drop  = (q.rseq == 2'd0) ? status[ST_EMPTY] : q.rdrop;
        push_drop = (q.wseq == 2'd0) ? status[ST_FULL]  : q.wdrop;

        if (req_valid) begin
            if (win == WIN_QUEUE) begin
                if (!req_write && k == q.rseq) begin
                    if (!pop_drop) rdata = rword;
                    if (q.rseq == 2'd0) begin
                        d.rdrop = status[ST_EMPTY];
                        if (status[ST_EMPTY]) d.uf = 1'b1;
                    end
                    if (FW'(q.rseq) == ewords - FW'(1)) begin
                        d.rseq = 2'd0;
                        if (!pop_drop) begin
                            d.rptr = wrap_add(q.rptr, ewords, q.size);
                            d.cnt  = q.cnt - FW'(1);
                        end
                    end else begin
                        d.rseq = q.rseq + 2'd1;
                    end
                end else if (req_write && k == q.wseq) begin
                    we_ram = !push_drop;
                    if (q.wseq == 2'd0) begin
                        d.wdrop = status[ST_FULL];
                        if (status[ST_FULL]) d.of = 1'b1;
                    end
                    if (FW'(q.wseq) == ewords - FW'(1)) begin
                        d.wseq = 2'd0;
                        if (!push_drop) begin
                            d.wptr = wrap_add(q.wptr, ewords, q.size);
                            d.cnt  = q.cnt + FW'(1);
                        end
                    end else begin
                        d.wseq = q.wseq + 2'd1;
                    end
                end
            end else if (win == WIN_PEEK) begin
                raddr = q.base + AW'(poff);
                waddr = q.base + AW'(poff);
                if (FW'(k) < ewords) begin
                    if (req_write) we_ram = 1'b1;
                    else           rdata  = rword;
                end
            end else begin
                case (req_addr)
                    REG_CFG: begin
                        if (req_write) begin
                            if (req_wdata[2*LANE +: 2] != ESZ_BAD) begin
                                d.base  = req_wdata[0 +: AW];
                                d.size  = req_wdata[LANE +: FW];
                                d.ecode = req_wdata[2*LANE +: 2];
                                d.rptr  = '0;
                                d.wptr  = '0;
                                d.cnt   = '0;
                                d.rseq  = '0;
                                d.wseq  = '0;
                                d.rdrop = 1'b0;
                                d.wdrop = 1'b0;
                            end
                        end else begin
                            rdata = DW'(q.base) | (DW'(q.size) << LANE)
                                  | (DW'(q.ecode) << (2*LANE));
                        end
                    end
                    REG_WMARK: begin
                        if (req_write) begin
                            d.ne_wm = req_wdata[0 +: FW];
                            d.nf_wm = req_wdata[LANE +: FW];
                        end else begin
                            rdata = DW'(q.ne_wm) | (DW'(q.nf_wm) << LANE);
                        end
                    end
                    REG_STATUS: begin
                        if (!req_write) rdata = DW'(status);
                    end
                    REG_FLAGS: begin
                        if (req_write) begin
                            d.uf = q.uf & req_wdata[FLAG_UF];
                            d.of = q.of & req_wdata[FLAG_OF];
                        end else begin
                            rdata = DW'({q.of, q.uf});
                        end
                    end
                    REG_PTRS: begin
                        if (!req_write) begin
                            rdata = DW'(q.rptr) | (DW'(q.wptr) << LANE)
                                  | (DW'(q.cnt) << (2*LANE));
                        end
                    end
                    REG_PIDX: begin
                        if (req_write) d.pidx = req_wdata[0 +: FW];
                        else           rdata  = DW'(q.pidx);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    assign underflow = q.uf;
    assign overflow  = q.of;
endmodule

// File: rtl/mwq_checker.sv
module mwq_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [3:0]    req_addr,
    input logic [DW-1:0] rdata,
    input logic [3:0]    status,
    input logic          underflow,
    input logic          overflow,
    input logic [1:0]    rseq,
    input logic [1:0]    wseq,
    input logic [1:0]    ecode
);
    import mwq_pkg::*;

    logic       first_pop, first_push, flag_wr, mid_push;
    logic [2:0] nwords;

    assign nwords     = 3'd1 << ecode;
    assign first_pop  = req_valid && !req_write && req_addr == 4'd0 && rseq == 2'd0;
    assign first_push = req_valid && req_write && req_addr == 4'd0 && wseq == 2'd0;
    assign flag_wr    = req_valid && req_write && req_addr == REG_FLAGS;
    assign mid_push   = req_valid && req_write && req_addr[3:2] == WIN_QUEUE
                        && req_addr[1:0] == wseq && ({1'b0, wseq} < nwords - 3'd1);

    AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        first_pop && status[ST_EMPTY] |-> rdata == '0);                 // R5
    AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        first_pop && status[ST_EMPTY] |=> underflow);                   // R5
    AST_OF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        first_push && status[ST_FULL] |=> overflow && $stable(status)); // R6
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow && !flag_wr |=> underflow);                           // R7
    AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !flag_wr |=> overflow);                             // R7
    AST_PARTIAL_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        mid_push |=> $stable(status));                                  // R4
    AST_EMPTY_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_EMPTY] |-> status[ST_NE]);                            // R8
endmodule

bind mwq_queue mwq_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rdata     (rdata),
    .status    (status),
    .underflow (underflow),
    .overflow  (overflow),
    .rseq      (q.rseq),
    .wseq      (q.wseq),
    .ecode     (q.ecode)
);

// File: tb/tb_mwq_queue.sv
module tb_mwq_queue;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  status;
    logic        underflow, overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mwq_queue dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata),
        .status(status), .underflow(underflow), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] a, input logic [31:0] wd,
                       output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        #1 rd = rdata;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] wd);
        logic [31:0] t;
        acc(1'b1, a, wd, t);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] t;
        acc(1'b0, a, '0, t);
        chk(tag, t, exp);
    endtask

    task automatic t_reset;
        chk("R1 status", 32'(status), 32'h3);
        chk("R1 flags", {30'd0, overflow, underflow}, 32'h0);
        rd_chk("R1 cfg", 4'd4, 32'h00001000);
        rd_chk("R1 ptrs", 4'd8, 32'h0);
        rd_chk("R1 wmark", 4'd5, 32'h0);
    endtask

    task automatic t_fifo_order;
        wr(4'd0, 32'hA1); wr(4'd0, 32'hA2); wr(4'd0, 32'hA3);
        rd_chk("R11 ptrs after push", 4'd8, 32'h00030300);
        rd_chk("R2 pop0", 4'd0, 32'hA1);
        rd_chk("R2 pop1", 4'd0, 32'hA2);
        rd_chk("R2 pop2", 4'd0, 32'hA3);
        chk("R2 empty again", 32'(status), 32'h3);
    endtask

    task automatic t_two_word;
        wr(4'd4, 32'h00010808);
        rd_chk("R3 cfg readback", 4'd4, 32'h00010808);
        wr(4'd0, 32'hB0);
        chk("R4 partial status", 32'(status), 32'h3);
        rd_chk("R4 partial ptrs", 4'd8, 32'h0);
        wr(4'd1, 32'hB1);
        chk("R4 complete status", 32'(status), 32'h0);
        rd_chk("R3 ptrs 2-word", 4'd8, 32'h00010200);
        rd_chk("R2 pop w0", 4'd0, 32'hB0);
        chk("R4 partial pop status", 32'(status), 32'h0);
        rd_chk("R2 pop w1", 4'd1, 32'hB1);
        chk("R4 pop done status", 32'(status), 32'h3);
    endtask

    task automatic t_full_overflow;
        wr(4'd4, 32'h00020810);
        for (int e = 0; e < 2; e++)
            for (int w = 0; w < 4; w++) wr(4'(w), 32'h10 * (e + 1) + w);
        chk("R8 full status", 32'(status), 32'hC);
        for (int w = 0; w < 4; w++) wr(4'(w), 32'hDEAD0 + w);
        chk("R6 overflow set", 32'(overflow), 32'h1);
        chk("R6 underflow clear", 32'(underflow), 32'h0);
        rd_chk("R6 ptrs unchanged", 4'd8, 32'h00020000);
        for (int w = 0; w < 4; w++) rd_chk("R6 entry0 intact", 4'(w), 32'h10 + w);
        for (int w = 0; w < 4; w++) rd_chk("R6 entry1 intact", 4'(w), 32'h20 + w);
    endtask

    task automatic t_underflow;
        wr(4'd4, 32'h00000800);
        rd_chk("R5 empty pop data", 4'd0, 32'h0);
        chk("R5 underflow set", 32'(underflow), 32'h1);
        rd_chk("R5 ptrs unchanged", 4'd8, 32'h0);
        rd_chk("R7 flags both", 4'd7, 32'h3);
        wr(4'd7, 32'h2);
        rd_chk("R7 clear uf only", 4'd7, 32'h2);
        wr(4'd0, 32'h77);
        chk("R7 of sticky after push", 32'(overflow), 32'h1);
        wr(4'd7, 32'h0);
        rd_chk("R7 clear all", 4'd7, 32'h0);
        rd_chk("R5 pop after clear", 4'd0, 32'h77);
    endtask

    task automatic t_watermarks;
        wr(4'd4, 32'h00000800);
        wr(4'd5, 32'h00000202);
        for (int n = 0; n <= 8; n++) begin
            logic [3:0] e;
            e = {n == 8, (8 - n) <= 2, n <= 2, n == 0};
            chk($sformatf("R8 status count %0d", n), 32'(status), 32'(e));
            if (n < 8) wr(4'd0, 32'(n));
        end
        wr(4'd5, 32'h0);
    endtask

    task automatic t_bad_code;
        wr(4'd4, 32'h00030820);
        rd_chk("R9 cfg unchanged", 4'd4, 32'h00000800);
        rd_chk("R9 ptrs unchanged", 4'd8, 32'h00080000);
    endtask

    task automatic t_peek_poke;
        wr(4'd4, 32'h00010820);
        for (int e = 1; e <= 3; e++) begin
            wr(4'd0, 32'h100 * e + 1);
            wr(4'd1, 32'h100 * e + 2);
        end
        wr(4'd9, 32'h1);
        rd_chk("R10 peek w0", 4'd12, 32'h201);
        rd_chk("R10 peek w1", 4'd13, 32'h202);
        rd_chk("R10 peek beyond entry", 4'd14, 32'h0);
        wr(4'd12, 32'h999);
        rd_chk("R10 ptrs unchanged", 4'd8, 32'h00030600);
        rd_chk("R10 pop e0 w0", 4'd0, 32'h101);
        rd_chk("R10 pop e0 w1", 4'd1, 32'h102);
        rd_chk("R10 poked w0", 4'd0, 32'h999);
        rd_chk("R10 untouched w1", 4'd1, 32'h202);
    endtask

    task automatic t_wrap;
        wr(4'd4, 32'h00000400);
        wr(4'd0, 32'hC1); wr(4'd0, 32'hC2); wr(4'd0, 32'hC3);
        rd_chk("R11 pop c1", 4'd0, 32'hC1);
        rd_chk("R11 pop c2", 4'd0, 32'hC2);
        wr(4'd0, 32'hC4); wr(4'd0, 32'hC5);
        rd_chk("R11 wrapped ptrs", 4'd8, 32'h00030102);
        rd_chk("R11 pop c3", 4'd0, 32'hC3);
        rd_chk("R11 pop c4", 4'd0, 32'hC4);
        rd_chk("R11 pop c5", 4'd0, 32'hC5);
    endtask

    task automatic t_out_of_seq;
        wr(4'd4, 32'h00010800);
        wr(4'd1, 32'hEE);
        chk("R12 status after stray write", 32'(status), 32'h3);
        rd_chk("R12 ptrs after stray write", 4'd8, 32'h0);
        wr(4'd0, 32'h55); wr(4'd1, 32'h66);
        rd_chk("R12 stray read data", 4'd1, 32'h0);
        rd_chk("R12 ptrs after stray read", 4'd8, 32'h00010200);
        rd_chk("R12 pop w0", 4'd0, 32'h55);
        rd_chk("R12 pop w1", 4'd1, 32'h66);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fifo_order();
        t_two_word();
        t_full_overflow();
        t_underflow();
        t_watermarks();
        t_bad_code();
        t_peek_poke();
        t_wrap();
        t_out_of_seq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule